// File: doc/BRIEF.md
# Programmable PWM Ramp Engine

This block drives three pulse-width-modulated outputs. A shared 8-bit counter advances once per input tick and wraps from 0xFF to 0x00. Each channel compares that counter with its own 8-bit level. The level is never written directly. A short program of 16-bit instructions, held in a 64-word memory inside each channel, sets it. Instructions can load a level, step it up or down over time, force the output fully low or fully high, stop, or jump back to the first word.

A host writes bytes through a simple address/data port. One control address holds the channel enable bits. Each channel also has its own load address. The host streams a program into that address one instruction at a time, upper byte first, while the channel is stopped. When the host sets the enable bit, the channel runs its program from the first word. When the host clears the bit, the channel stops and its output goes low. A typical use is a smooth fade of an LED: load a start level, ramp to a target, then halt or loop.

Top module: `pwm_ramp_engine`

## Requirements
- R1: After reset all channels are disabled and every `pwm_o` bit is low.
- R2: On each tick the 8-bit counter increments and wraps from 0xFF to 0x00. While a channel is in compare mode its output is high exactly when its level is greater than or equal to the counter. Over any 256 consecutive ticks with a constant level L, the output is therefore high for L+1 ticks.
- R3: Writing address 0x30 sets the enable bits: bit 0 enables channel 0, bit 1 channel 1 and bit 2 channel 2. A cleared bit stops its channel, returns its program counter to 0 and holds its output low. Setting the bit again runs the stored program from word 0.
- R4: Channels 0, 1 and 2 load their programs through addresses 0x38, 0x39 and 0x3A. While a channel is disabled, its first byte written is the upper half of an instruction and its second byte is the lower half. The second byte stores the whole word at the channel's write pointer, and the pointer then increments.
- R5: The write pointer wraps from 63 to 0, so the 65th word overwrites word 0. The pointer returns to 0 when the channel's enable bit goes from 1 to 0.
- R6: Bytes written to a channel's load address while that channel is enabled are ignored.
- R7: A word with bit 14 set and bits 15 and 13 clear loads its bits 7:0 into the level and selects compare mode.
- R8: Word 0x007F holds the output low. Word 0x00FF holds it high. Word 0x0000 halts the program at that word and keeps the current level.
- R9: A word with bits 15 and 13 both set jumps to word 0.
- R10: Any other word is a ramp. Bit 7 is the direction (0 up, 1 down) and bits 6:0 are the number of unit steps. Bit 14 picks a step-clock pulse every 512 ticks, otherwise every 16 ticks. Bits 12:8 give T, and one step occurs on every (T+1)th step-clock pulse. After the last step the program moves to the next word.
- R11: Ramping saturates: the level never goes below 0x00 or above 0xFF.
- R12: The three channels run independently. Each has its own program, level and enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter and prescaler advance pulse |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 8 | Write address |
| wdata_i | input | 8 | Write data byte |
| pwm_o | output | 3 | PWM outputs, one per channel |

## Verification
On every cycle the assertions check several properties:
- a disabled channel is low and at word 0;
- a running ramp changes its level by at most one per cycle;
- a halt word freezes the program counter and the level;
- a jump word lands on word 0;
- a write to a locked channel leaves its load state untouched;
- disabling a channel clears its write pointer.

Only the directed scenarios can show the things a single-cycle check cannot observe. These are the duty ratio seen over a whole 256-tick period, the levels reached at the end of a ramp, the saturation points, the step rate of each prescaler and step-time setting (measured against a tick count aligned to the prescaler), and where a wrapped or reset pointer writes into program memory.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

  localparam int NUM_CH     = 3;
  localparam int PROG_DEPTH = 64;
  localparam int LEVEL_W    = 8;
  localparam int INSTR_W    = 16;
  localparam int FAST_DIV   = 16;
  localparam int SLOW_DIV   = 512;
  localparam logic [7:0] CTRL_ADDR = 8'h30;
  localparam logic [7:0] PROG_BASE = 8'h38;

  typedef enum logic [1:0] {
    OUT_OFF,
    OUT_ON,
    OUT_CMP
  } out_mode_e;

  typedef enum logic [2:0] {
    OP_BRANCH,
    OP_LOAD,
    OP_FORCE_OFF,
    OP_FORCE_ON,
    OP_HALT,
    OP_RAMP
  } op_e;

  // Priority order matters: jump, load, exact codes, then ramp.
  function automatic op_e decode_op(input logic [INSTR_W-1:0] w);
    if (w[15] && w[13])                 return OP_BRANCH;
    else if (w[14] && !w[15] && !w[13]) return OP_LOAD;
    else if (w == 16'h007F)             return OP_FORCE_OFF;
    else if (w == 16'h00FF)             return OP_FORCE_ON;
    else if (w == 16'h0000)             return OP_HALT;
    else                                return OP_RAMP;
  endfunction

endpackage

// File: rtl/pwm_ramp_timebase.sv
module pwm_ramp_timebase #(
  parameter int CNT_W    = 8,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fast_o,
  output logic             slow_o
);

  localparam int FAST_W = $clog2(FAST_DIV);
  localparam int SLOW_W = $clog2(SLOW_DIV);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SLOW_W-1:0] pre_q, pre_n;

  always_comb begin
    cnt_n = cnt_q;
    pre_n = pre_q;
    if (tick_i) begin
      cnt_n = cnt_q + 1'b1;
      pre_n = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      pre_q <= pre_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign fast_o = tick_i && (&pre_q[FAST_W-1:0]);
  assign slow_o = tick_i && (&pre_q);

endmodule

// File: rtl/pwm_ramp_regs.sv
module pwm_ramp_regs
  import pwm_ramp_pkg::*;
#(
  parameter int         CH_N    = 3,
  parameter int         ADDR_W  = 6,
  parameter int         WORD_W  = 16,
  parameter logic [7:0] CTRL_A  = 8'h30,
  parameter logic [7:0] LOAD_A  = 8'h38
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [7:0]                    addr_i,
  input  logic [7:0]                    wdata_i,
  output logic [CH_N-1:0]               en_o,
  output logic [CH_N-1:0]               we_o,
  output logic [CH_N-1:0][ADDR_W-1:0]   waddr_o,
  output logic [WORD_W-1:0]             wword_o
);

  localparam int HALF_W = WORD_W / 2;

  logic [CH_N-1:0]             en_q, en_n;
  logic [CH_N-1:0]             phase_q, phase_n;
  logic [CH_N-1:0][HALF_W-1:0] hold_q, hold_n;
  logic [CH_N-1:0][ADDR_W-1:0] wptr_q, wptr_n;

  always_comb begin
    en_n    = en_q;
    phase_n = phase_q;
    hold_n  = hold_q;
    wptr_n  = wptr_q;
    we_o    = '0;
    wword_o = '0;
    if (wr_en_i && addr_i == CTRL_A) begin
      en_n = wdata_i[CH_N-1:0];
      for (int ch = 0; ch < CH_N; ch++) begin
        if (en_q[ch] && !wdata_i[ch]) begin
          wptr_n[ch]  = '0;
          phase_n[ch] = 1'b0;
        end
      end
    end
    for (int ch = 0; ch < CH_N; ch++) begin
      if (wr_en_i && addr_i == 8'(LOAD_A + ch) && !en_q[ch]) begin
        if (!phase_q[ch]) begin
          hold_n[ch]  = wdata_i;
          phase_n[ch] = 1'b1;
        end else begin
          we_o[ch]    = 1'b1;
          wword_o     = {hold_q[ch], wdata_i};
          wptr_n[ch]  = wptr_q[ch] + 1'b1;
          phase_n[ch] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      phase_q <= '0;
      hold_q  <= '0;
      wptr_q  <= '0;
    end else begin
      en_q    <= en_n;
      phase_q <= phase_n;
      hold_q  <= hold_n;
      wptr_q  <= wptr_n;
    end
  end

  assign en_o    = en_q;
  assign waddr_o = wptr_q;

  for (genvar c = 0; c < CH_N; c++) begin : g_chk
    // R6: a locked channel keeps its pointer and held byte
    assert_locked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == 8'(LOAD_A + c) && en_q[c])
      |=> ($stable(wptr_q[c]) && $stable(hold_q[c])));
    // R5: disabling a channel leaves its pointer at word 0
    assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[c]) |-> (wptr_q[c] == '0));
  end

endmodule

// File: rtl/pwm_ramp_channel.sv
module pwm_ramp_channel
  import pwm_ramp_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int LVL_W   = 8,
  parameter int WORD_W  = 16,
  parameter int STEP_W  = 5,
  parameter int COUNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              fast_i,
  input  logic              slow_i,
  input  logic [LVL_W-1:0]  cnt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wword_i,
  output logic              pwm_o
);

  logic [WORD_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0]  pc_q, pc_n;
  logic [LVL_W-1:0]   level_q, level_n;
  out_mode_e          mode_q, mode_n;
  logic               ramp_q, ramp_n;
  logic [COUNT_W-1:0] remain_q, remain_n;
  logic [STEP_W-1:0]  timer_q, timer_n;
  logic               out_q, out_n;

  logic [WORD_W-1:0]  instr;
  op_e                op;
  logic               step_pulse;
  logic [STEP_W-1:0]  step_time;
  logic [COUNT_W-1:0] step_cnt;
  logic               go_down;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wword_i;
  end

  assign instr      = mem[pc_q];
  assign op         = decode_op(instr);
  assign step_pulse = instr[14] ? slow_i : fast_i;
  assign step_time  = instr[8 +: STEP_W];
  assign step_cnt   = instr[COUNT_W-1:0];
  assign go_down    = instr[7];

  always_comb begin
    pc_n     = pc_q;
    level_n  = level_q;
    mode_n   = mode_q;
    ramp_n   = ramp_q;
    remain_n = remain_q;
    timer_n  = timer_q;
    if (!en_i) begin
      pc_n     = '0;
      level_n  = '0;
      mode_n   = OUT_OFF;
      ramp_n   = 1'b0;
      remain_n = '0;
      timer_n  = '0;
    end else begin
      case (op)
        OP_BRANCH: pc_n = '0;
        OP_LOAD: begin
          level_n = instr[LVL_W-1:0];
          mode_n  = OUT_CMP;
          pc_n    = pc_q + 1'b1;
        end
        OP_FORCE_OFF: begin
          mode_n = OUT_OFF;
          pc_n   = pc_q + 1'b1;
        end
        OP_FORCE_ON: begin
          mode_n = OUT_ON;
          pc_n   = pc_q + 1'b1;
        end
        OP_HALT: ;
        OP_RAMP: begin
          if (!ramp_q) begin
            mode_n = OUT_CMP;
            if (step_cnt == '0) begin
              pc_n = pc_q + 1'b1;
            end else begin
              ramp_n   = 1'b1;
              remain_n = step_cnt;
              timer_n  = '0;
            end
          end else if (remain_q == '0) begin
            ramp_n = 1'b0;
            pc_n   = pc_q + 1'b1;
          end else if (step_pulse) begin
            if (timer_q == step_time) begin
              timer_n  = '0;
              remain_n = remain_q - 1'b1;
              if (go_down) level_n = (level_q == '0) ? '0 : level_q - 1'b1;
              else         level_n = (&level_q) ? level_q : level_q + 1'b1;
            end else begin
              timer_n = timer_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign out_n = en_i && ((mode_q == OUT_ON) ||
                          (mode_q == OUT_CMP && level_q >= cnt_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      level_q  <= '0;
      mode_q   <= OUT_OFF;
      ramp_q   <= 1'b0;
      remain_q <= '0;
      timer_q  <= '0;
      out_q    <= 1'b0;
    end else begin
      pc_q     <= pc_n;
      level_q  <= level_n;
      mode_q   <= mode_n;
      ramp_q   <= ramp_n;
      remain_q <= remain_n;
      timer_q  <= timer_n;
      out_q    <= out_n;
    end
  end

  assign pwm_o = out_q;

  assert_disabled_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!pwm_o && pc_q == '0));

  assert_unit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_q && $past(ramp_q)) |->
      (level_q == $past(level_q) || level_q == $past(level_q) + 1'b1 ||
       level_q == $past(level_q) - 1'b1));

  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op == OP_HALT) |=> (!en_i || ($stable(pc_q) && $stable(level_q))));

  assert_force_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OUT_OFF) |=> !pwm_o);

  assert_branch_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op == OP_BRANCH) |=> (pc_q == '0));

endmodule

// File: rtl/pwm_ramp_engine.sv
module pwm_ramp_engine
  import pwm_ramp_pkg::*;
#(
  parameter int CH_N  = NUM_CH,
  parameter int DEPTH = PROG_DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic [7:0]      addr_i,
  input  logic [7:0]      wdata_i,
  output logic [CH_N-1:0] pwm_o
);

  localparam int ADDR_W = $clog2(DEPTH);

  logic                          rst_meta_q, rst_sync_q;
  logic [LEVEL_W-1:0]            cnt;
  logic                          fast, slow;
  logic [CH_N-1:0]               en;
  logic [CH_N-1:0]               we;
  logic [CH_N-1:0][ADDR_W-1:0]   waddr;
  logic [INSTR_W-1:0]            wword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pwm_ramp_timebase #(
    .CNT_W    (LEVEL_W),
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) i_timebase (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .fast_o (fast),
    .slow_o (slow)
  );

  pwm_ramp_regs #(
    .CH_N   (CH_N),
    .ADDR_W (ADDR_W),
    .WORD_W (INSTR_W),
    .CTRL_A (CTRL_ADDR),
    .LOAD_A (PROG_BASE)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .en_o    (en),
    .we_o    (we),
    .waddr_o (waddr),
    .wword_o (wword)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm_ramp_channel #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .LVL_W  (LEVEL_W),
      .WORD_W (INSTR_W)
    ) i_channel (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .en_i    (en[c]),
      .fast_i  (fast),
      .slow_i  (slow),
      .cnt_i   (cnt),
      .we_i    (we[c]),
      .waddr_i (waddr[c]),
      .wword_i (wword),
      .pwm_o   (pwm_o[c])
    );
  end

endmodule

// File: tb/test_pwm_ramp_engine.sv
module test_pwm_ramp_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       wr_en_i;
  logic [7:0] addr_i;
  logic [7:0] wdata_i;
  logic [2:0] pwm_o;

  int errors = 0;
  int checks = 0;
  int tick_total = 0;
  int hi [3];

  always #5 clk = ~clk;

  pwm_ramp_engine i_pwm_ramp_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pwm_o   (pwm_o)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] w);
    wr(8'(8'h38 + ch), w[15:8]);
    wr(8'(8'h38 + ch), w[7:0]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_total++;
    end
    tick_i = 1'b0;
  endtask

  // Count high samples per channel over one full counter period
  task automatic measure();
    for (int c = 0; c < 3; c++) hi[c] = 0;
    for (int k = 0; k < 256; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_total++;
      for (int c = 0; c < 3; c++) hi[c] += int'(pwm_o[c]);
    end
    tick_i = 1'b0;
  endtask

  task automatic start(input logic [7:0] mask);
    wr(8'h30, mask);
    idle(4);
  endtask

  task automatic t_reset();
    check(int'(pwm_o), 0, "R1", "outputs after reset");
    measure();
    check(hi[0] + hi[1] + hi[2], 0, "R1", "no pulses while disabled");
  endtask

  task automatic t_load_compare();
    wr(8'h30, 8'h00);
    prog(0, 16'h4020); prog(0, 16'h0000);
    prog(1, 16'h4000); prog(1, 16'h0000);
    prog(2, 16'h40C3); prog(2, 16'h0000);
    start(8'h07);
    measure();
    check(hi[0], 33,  "R2", "level 0x20 duty");
    check(hi[1], 1,   "R7", "level 0x00 still high at count 0");
    check(hi[2], 196, "R12", "channel 2 independent level 0xC3");
  endtask

  task automatic t_force_halt();
    wr(8'h30, 8'h00);
    prog(0, 16'h007F); prog(0, 16'h0000);
    prog(1, 16'h00FF); prog(1, 16'h0000);
    prog(2, 16'h4020); prog(2, 16'h0000); prog(2, 16'h4090);
    start(8'h07);
    run_ticks(40);
    measure();
    check(hi[0], 0,   "R8", "0x007F holds low");
    check(hi[1], 256, "R8", "0x00FF holds high");
    check(hi[2], 33,  "R8", "0x0000 halts before later load");
  endtask

  task automatic t_enable_control();
    wr(8'h30, 8'h00);
    prog(0, 16'h4040); prog(0, 16'h0000);
    prog(1, 16'h00FF); prog(1, 16'h0000);
    start(8'h03);
    measure();
    check(hi[1], 256, "R3", "channel 1 running");
    start(8'h01);
    measure();
    check(hi[1], 0,  "R3", "cleared bit forces low");
    check(hi[0], 65, "R12", "channel 0 unaffected by channel 1 stop");
    start(8'h03);
    measure();
    check(hi[1], 256, "R3", "restart runs stored program");
  endtask

  task automatic t_locked_write();
    wr(8'h30, 8'h00);
    prog(1, 16'h4020); prog(1, 16'h0000);
    start(8'h02);
    start(8'h00);
    start(8'h02);
    prog(1, 16'h4070);
    start(8'h00);
    start(8'h02);
    measure();
    check(hi[1], 33, "R6", "write while enabled dropped");
  endtask

  task automatic t_pointer_reset();
    wr(8'h30, 8'h00);
    prog(0, 16'h4010);
    start(8'h01);
    start(8'h00);
    prog(0, 16'h4060); prog(0, 16'h0000);
    start(8'h01);
    measure();
    check(hi[0], 97, "R5", "pointer back at word 0 after disable");
    check(int'(pwm_o[1]), 0, "R4", "channel 1 not enabled");
  endtask

  task automatic t_pointer_wrap();
    wr(8'h30, 8'h00);
    prog(1, 16'h4010);
    for (int k = 1; k < 64; k++) prog(1, 16'h0000);
    prog(1, 16'h4050);
    start(8'h02);
    measure();
    check(hi[1], 81, "R5", "65th word overwrote word 0");
  endtask

  task automatic t_ramps();
    wr(8'h30, 8'h00);
    prog(0, 16'h4010); prog(0, 16'h0020); prog(0, 16'h0000);
    prog(1, 16'h4080); prog(1, 16'h0090); prog(1, 16'h0000);
    prog(2, 16'h4005); prog(2, 16'h0090); prog(2, 16'h0000);
    start(8'h07);
    run_ticks(800);
    measure();
    check(hi[0], 49,  "R10", "ramp up 32 from 0x10");
    check(hi[1], 113, "R10", "ramp down 16 from 0x80");
    check(hi[2], 1,   "R11", "ramp down clamps at 0x00");
  endtask

  task automatic t_branch_saturate();
    wr(8'h30, 8'h00);
    prog(0, 16'h40F8); prog(0, 16'h0010); prog(0, 16'h0000);
    prog(1, 16'h0001); prog(1, 16'hA000);
    prog(2, 16'h4030); prog(2, 16'hA000); prog(2, 16'h4090);
    start(8'h07);
    run_ticks(9000);
    measure();
    check(hi[0], 256, "R11", "ramp up clamps at 0xFF");
    check(hi[1], 256, "R9", "looped single step reaches top");
    check(hi[2], 49,  "R9", "jump skips later load");
  endtask

  task automatic t_step_rate();
    wr(8'h30, 8'h00);
    prog(0, 16'h4000); prog(0, 16'h6064); prog(0, 16'h0000);
    prog(1, 16'h4000); prog(1, 16'h1F64); prog(1, 16'h0000);
    prog(2, 16'h4000); prog(2, 16'h6164); prog(2, 16'h0000);
    run_ticks((512 - (tick_total % 512)) % 512);
    start(8'h07);
    run_ticks(1236);
    measure();
    check(hi[0], 3, "R10", "slow prescale step every 512 ticks");
    check(hi[1], 3, "R10", "fast prescale with step time 31");
    check(hi[2], 2, "R10", "slow prescale with step time 1");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    tick_i  = 1'b0;
    wr_en_i = 1'b0;
    addr_i  = '0;
    wdata_i = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_load_compare();
    t_force_halt();
    t_enable_control();
    t_locked_write();
    t_pointer_reset();
    t_pointer_wrap();
    t_ramps();
    t_branch_saturate();
    t_step_rate();
    finish_run();
  end

endmodule